// File: doc/BRIEF.md
# Raster Sync and Blanking Timer

This block produces the horizontal and vertical timing of a non-interlaced character display. It counts character times along each scan line and scan lines down the frame. From those counts it decodes horizontal blanking, horizontal sync, vertical blanking, vertical sync, a flag for the visible region and a one-cycle end-of-frame pulse. It also presents the current scan-line number and character-row number to the logic that fetches characters and pixels. The clock is the character clock, so each cycle is one character time.

A scan line is always 100 character times long: 80 visible and 20 for horizontal retrace. The frame length is chosen at run time. It is 262 lines for a 60 Hz field or 314 lines for a 50 Hz field, so the line rate is the same in both settings. The visible area is 12 character rows. A line belongs to vertical retrace whenever its character row, which is the upper part of the line position, has passed the last visible row. All counts and sync spans are parameters.

Top module: `raster_timer`

## Requirements
- R1: `hBlank` is low for character times 0 to 79 of every line and high for character times 80 to 99.
- R2: `hSync` is high exactly at character times 84 to 91 of every line, which lies inside horizontal blanking.
- R3: `lineNum` holds its value during a line and steps by one when the character time wraps from 99 to 0.
- R4: With the frame rate set to 60 Hz (`mode50` = 0), a frame lasts 262 lines (26200 cycles) and its last line is 261.
- R5: With the frame rate set to 50 Hz (`mode50` = 1), a frame lasts 314 lines (31400 cycles) and its last line is 313.
- R6: `mode50` is sampled only at the last cycle of a frame. A change in the middle of a frame does not alter that frame's length, and the first frame after reset is always a 60 Hz frame.
- R7: `charRow` equals `lineNum` divided by 10. `vBlank` is high exactly when `charRow` is 12 or more, starting from line 120.
- R8: `vSync` is high exactly on lines 190 to 192, which lie inside vertical blanking.
- R9: `displayOn` is high exactly when neither `hBlank` nor `vBlank` is high.
- R10: `frameEnd` is high for the single cycle at character time 99 of the last line. In the following cycle `lineNum` and `charRow` are 0.
- R11: While `rstN` is low, the block sits at the first character of line 0. `lineNum` and `charRow` are 0, all blanking, sync and `frameEnd` outputs are low, and `displayOn` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Character clock, one cycle per character time |
| rstN | input | 1 | Active-low synchronous reset |
| mode50 | input | 1 | Frame-rate select: 1 = 314-line frame, 0 = 262-line frame |
| hBlank | output | 1 | Horizontal blanking |
| hSync | output | 1 | Horizontal sync |
| vBlank | output | 1 | Vertical blanking |
| vSync | output | 1 | Vertical sync |
| displayOn | output | 1 | Beam is inside the visible area |
| frameEnd | output | 1 | One-cycle pulse on the last character of a frame |
| lineNum | output | 9 | Current scan line |
| charRow | output | 6 | Current character row |

## Verification
The checker keeps its own character-time counter, aligned to reset. On every cycle it uses that counter to confirm the horizontal blanking window, that the line number is steady in the middle of a line, and that `frameEnd` falls only on the last character time. It also confirms that each sync lies inside its blanking, that the display flag excludes both blankings, that vertical blanking starts on the first line past the visible rows, and that the counters return to zero after `frameEnd`. Some behaviour only the bench scenarios can show: the exact frame lengths in each mode, the deferral of a mid-frame mode change to the next frame, and the exact positions of the sync spans.

// File: rtl/raster_timer_pkg.sv
package raster_timer_pkg;

  // Strobes from the control to the datapath, valid in the current cycle.
  typedef struct packed {
    logic lineEnd;   // last character time of a line
    logic rowEnd;    // last character of the last line of a character row
    logic frameEnd;  // last character of the last line of the frame
  } rasterStrobe_t;

endpackage

// File: rtl/raster_timer_ctrl.sv
module raster_timer_ctrl
  import raster_timer_pkg::*;
#(
  parameter int CHARS_PER_LINE = 100,
  parameter int LINES_PER_ROW  = 10,
  parameter int LINES_60HZ     = 262,
  parameter int LINES_50HZ     = 314,
  parameter int CHAR_W         = 7,
  parameter int LINE_W         = 9,
  parameter int SUB_W          = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mode50,
  input  logic [CHAR_W-1:0] charCnt,
  input  logic [LINE_W-1:0] lineCnt,
  input  logic [SUB_W-1:0]  subLine,
  output rasterStrobe_t     strobe,
  output logic [LINE_W-1:0] lastLine
);

  localparam logic [CHAR_W-1:0] LAST_CHAR = CHAR_W'(CHARS_PER_LINE - 1);
  localparam logic [SUB_W-1:0]  LAST_SUB  = SUB_W'(LINES_PER_ROW - 1);
  localparam logic [LINE_W-1:0] LAST_60   = LINE_W'(LINES_60HZ - 1);
  localparam logic [LINE_W-1:0] LAST_50   = LINE_W'(LINES_50HZ - 1);

  logic use50;

  // The frame-rate choice is taken only at the frame boundary.
  always_ff @(posedge clk) begin
    if (!rstN)                use50 <= 1'b0;
    else if (strobe.frameEnd) use50 <= mode50;
  end

  assign lastLine = use50 ? LAST_50 : LAST_60;

  always_comb begin
    strobe.lineEnd  = (charCnt == LAST_CHAR);
    strobe.rowEnd   = strobe.lineEnd && (subLine == LAST_SUB);
    strobe.frameEnd = strobe.lineEnd && (lineCnt == lastLine);
  end

endmodule

// File: rtl/raster_timer_dp.sv
module raster_timer_dp
  import raster_timer_pkg::*;
#(
  parameter int CHARS_PER_LINE = 100,
  parameter int ACTIVE_CHARS   = 80,
  parameter int HSYNC_FIRST    = 84,
  parameter int HSYNC_LAST     = 91,
  parameter int ACTIVE_ROWS    = 12,
  parameter int VSYNC_FIRST    = 190,
  parameter int VSYNC_LAST     = 192,
  parameter int CHAR_W         = 7,
  parameter int LINE_W         = 9,
  parameter int SUB_W          = 4,
  parameter int ROW_W          = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  rasterStrobe_t     strobe,
  input  logic [LINE_W-1:0] lastLine,
  output logic [CHAR_W-1:0] charCnt,
  output logic [LINE_W-1:0] lineCnt,
  output logic [SUB_W-1:0]  subLine,
  output logic [ROW_W-1:0]  rowCnt,
  output logic              hBlank,
  output logic              hSync,
  output logic              vBlank,
  output logic              vSync,
  output logic              displayOn,
  output logic              frameEnd
);

  localparam logic [CHAR_W-1:0] LAST_CHAR = CHAR_W'(CHARS_PER_LINE - 1);
  localparam logic [CHAR_W-1:0] HB_START  = CHAR_W'(ACTIVE_CHARS);
  localparam logic [CHAR_W-1:0] HS_FIRST  = CHAR_W'(HSYNC_FIRST);
  localparam logic [CHAR_W-1:0] HS_LAST   = CHAR_W'(HSYNC_LAST);
  localparam logic [ROW_W-1:0]  VB_ROW    = ROW_W'(ACTIVE_ROWS);
  localparam logic [LINE_W-1:0] VS_FIRST  = LINE_W'(VSYNC_FIRST);
  localparam logic [LINE_W-1:0] VS_LAST   = LINE_W'(VSYNC_LAST);

  logic [CHAR_W-1:0] nChar;
  logic [LINE_W-1:0] nLine;
  logic [SUB_W-1:0]  nSub;
  logic [ROW_W-1:0]  nRow;
  logic nHBlank, nVBlank;

  // Next position of the beam.
  always_comb begin
    nChar = charCnt + 1'b1;
    nLine = lineCnt;
    nSub  = subLine;
    nRow  = rowCnt;
    if (strobe.frameEnd) begin
      nChar = '0;
      nLine = '0;
      nSub  = '0;
      nRow  = '0;
    end else if (strobe.lineEnd) begin
      nChar = '0;
      nLine = lineCnt + 1'b1;
      if (strobe.rowEnd) begin
        nSub = '0;
        nRow = rowCnt + 1'b1;
      end else begin
        nSub = subLine + 1'b1;
      end
    end
  end

  // Decode the next position so that outputs line up with the counters.
  assign nHBlank = (nChar >= HB_START);
  assign nVBlank = (nRow >= VB_ROW);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      charCnt   <= '0;
      lineCnt   <= '0;
      subLine   <= '0;
      rowCnt    <= '0;
      hBlank    <= 1'b0;
      hSync     <= 1'b0;
      vBlank    <= 1'b0;
      vSync     <= 1'b0;
      displayOn <= 1'b1;
      frameEnd  <= 1'b0;
    end else begin
      charCnt   <= nChar;
      lineCnt   <= nLine;
      subLine   <= nSub;
      rowCnt    <= nRow;
      hBlank    <= nHBlank;
      hSync     <= (nChar >= HS_FIRST) && (nChar <= HS_LAST);
      vBlank    <= nVBlank;
      vSync     <= (nLine >= VS_FIRST) && (nLine <= VS_LAST);
      displayOn <= !nHBlank && !nVBlank;
      frameEnd  <= (nLine == lastLine) && (nChar == LAST_CHAR);
    end
  end

endmodule

// File: rtl/raster_timer.sv
module raster_timer
  import raster_timer_pkg::*;
#(
  parameter int CHARS_PER_LINE = 100,
  parameter int ACTIVE_CHARS   = 80,
  parameter int HSYNC_FIRST    = 84,
  parameter int HSYNC_LAST     = 91,
  parameter int LINES_PER_ROW  = 10,
  parameter int ACTIVE_ROWS    = 12,
  parameter int LINES_60HZ     = 262,
  parameter int LINES_50HZ     = 314,
  parameter int VSYNC_FIRST    = 190,
  parameter int VSYNC_LAST     = 192,
  localparam int MAX_LINES     = (LINES_50HZ > LINES_60HZ) ? LINES_50HZ : LINES_60HZ,
  localparam int MAX_ROWS      = (MAX_LINES + LINES_PER_ROW - 1) / LINES_PER_ROW,
  localparam int CHAR_W        = $clog2(CHARS_PER_LINE),
  localparam int LINE_W        = $clog2(MAX_LINES),
  localparam int SUB_W         = $clog2(LINES_PER_ROW + 1),
  localparam int ROW_W         = $clog2(MAX_ROWS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mode50,
  output logic              hBlank,
  output logic              hSync,
  output logic              vBlank,
  output logic              vSync,
  output logic              displayOn,
  output logic              frameEnd,
  output logic [LINE_W-1:0] lineNum,
  output logic [ROW_W-1:0]  charRow
);

  rasterStrobe_t     strobe;
  logic [LINE_W-1:0] lastLine;
  logic [CHAR_W-1:0] charCnt;
  logic [SUB_W-1:0]  subLine;

  raster_timer_ctrl #(
    .CHARS_PER_LINE(CHARS_PER_LINE),
    .LINES_PER_ROW (LINES_PER_ROW),
    .LINES_60HZ    (LINES_60HZ),
    .LINES_50HZ    (LINES_50HZ),
    .CHAR_W        (CHAR_W),
    .LINE_W        (LINE_W),
    .SUB_W         (SUB_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .mode50  (mode50),
    .charCnt (charCnt),
    .lineCnt (lineNum),
    .subLine (subLine),
    .strobe  (strobe),
    .lastLine(lastLine)
  );

  raster_timer_dp #(
    .CHARS_PER_LINE(CHARS_PER_LINE),
    .ACTIVE_CHARS  (ACTIVE_CHARS),
    .HSYNC_FIRST   (HSYNC_FIRST),
    .HSYNC_LAST    (HSYNC_LAST),
    .ACTIVE_ROWS   (ACTIVE_ROWS),
    .VSYNC_FIRST   (VSYNC_FIRST),
    .VSYNC_LAST    (VSYNC_LAST),
    .CHAR_W        (CHAR_W),
    .LINE_W        (LINE_W),
    .SUB_W         (SUB_W),
    .ROW_W         (ROW_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .lastLine (lastLine),
    .charCnt  (charCnt),
    .lineCnt  (lineNum),
    .subLine  (subLine),
    .rowCnt   (charRow),
    .hBlank   (hBlank),
    .hSync    (hSync),
    .vBlank   (vBlank),
    .vSync    (vSync),
    .displayOn(displayOn),
    .frameEnd (frameEnd)
  );

endmodule

// File: rtl/raster_timer_chk.sv
module raster_timer_chk #(
  parameter int CHARS_PER_LINE = 100,
  parameter int ACTIVE_CHARS   = 80,
  parameter int LINES_PER_ROW  = 10,
  parameter int ACTIVE_ROWS    = 12,
  parameter int LINE_W         = 9,
  parameter int ROW_W          = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              hBlank,
  input logic              hSync,
  input logic              vBlank,
  input logic              vSync,
  input logic              displayOn,
  input logic              frameEnd,
  input logic [LINE_W-1:0] lineNum,
  input logic [ROW_W-1:0]  charRow
);

  localparam int CW = $clog2(CHARS_PER_LINE);
  localparam logic [CW-1:0]     LAST_T   = CW'(CHARS_PER_LINE - 1);
  localparam logic [CW-1:0]     HB_T     = CW'(ACTIVE_CHARS);
  localparam logic [LINE_W-1:0] VB_LINE  = LINE_W'(ACTIVE_ROWS * LINES_PER_ROW);

  // Independent character-time counter, aligned to reset.
  logic [CW-1:0] chkChar;
  always_ff @(posedge clk) begin
    if (!rstN)                 chkChar <= '0;
    else if (chkChar == LAST_T) chkChar <= '0;
    else                       chkChar <= chkChar + 1'b1;
  end

  a_r1_hblank_window: assert property (@(posedge clk) disable iff (!rstN)
    hBlank == (chkChar >= HB_T));

  a_r2_hsync_in_blank: assert property (@(posedge clk) disable iff (!rstN)
    hSync |-> hBlank);

  a_r3_line_steady: assert property (@(posedge clk) disable iff (!rstN)
    (chkChar != '0) |-> $stable(lineNum));

  a_r7_vblank_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(vBlank) |-> (lineNum == VB_LINE));

  a_r8_vsync_in_blank: assert property (@(posedge clk) disable iff (!rstN)
    vSync |-> vBlank);

  a_r9_display_clear: assert property (@(posedge clk) disable iff (!rstN)
    displayOn |-> (!hBlank && !vBlank));

  a_r10_end_last_char: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |-> (chkChar == LAST_T));

  a_r10_wrap_zero: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |=> (lineNum == '0 && charRow == '0 && !frameEnd));

endmodule

bind raster_timer raster_timer_chk #(
  .CHARS_PER_LINE(CHARS_PER_LINE),
  .ACTIVE_CHARS  (ACTIVE_CHARS),
  .LINES_PER_ROW (LINES_PER_ROW),
  .ACTIVE_ROWS   (ACTIVE_ROWS),
  .LINE_W        (LINE_W),
  .ROW_W         (ROW_W)
) u_chk (.*);

// File: tb/raster_timer_tb.sv
`timescale 1ns/1ps
module raster_timer_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mode50 = 1'b0;
  logic hBlank, hSync, vBlank, vSync, displayOn, frameEnd;
  logic [8:0] lineNum;
  logic [5:0] charRow;

  int checks = 0;
  int failures = 0;
  int pos = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  raster_timer u_dut (
    .clk(clk), .rstN(rstN), .mode50(mode50),
    .hBlank(hBlank), .hSync(hSync), .vBlank(vBlank), .vSync(vSync),
    .displayOn(displayOn), .frameEnd(frameEnd),
    .lineNum(lineNum), .charRow(charRow)
  );

  // flags = {hBlank, hSync, vBlank, vSync, displayOn, frameEnd}
  typedef struct packed {
    logic [8:0] line;
    logic [6:0] ch;
    logic [5:0] row;
    logic [5:0] flags;
  } vec_t;

  localparam int NVEC = 18;
  localparam vec_t VECS [NVEC] = '{
    '{9'd0,   7'd0,  6'd0,  6'b000010},
    '{9'd0,   7'd79, 6'd0,  6'b000010},
    '{9'd0,   7'd80, 6'd0,  6'b100000},
    '{9'd0,   7'd83, 6'd0,  6'b100000},
    '{9'd0,   7'd84, 6'd0,  6'b110000},
    '{9'd0,   7'd91, 6'd0,  6'b110000},
    '{9'd0,   7'd92, 6'd0,  6'b100000},
    '{9'd0,   7'd99, 6'd0,  6'b100000},
    '{9'd9,   7'd50, 6'd0,  6'b000010},
    '{9'd10,  7'd0,  6'd1,  6'b000010},
    '{9'd119, 7'd79, 6'd11, 6'b000010},
    '{9'd119, 7'd80, 6'd11, 6'b100000},
    '{9'd120, 7'd0,  6'd12, 6'b001000},
    '{9'd189, 7'd10, 6'd18, 6'b001000},
    '{9'd190, 7'd10, 6'd19, 6'b001100},
    '{9'd192, 7'd85, 6'd19, 6'b111100},
    '{9'd193, 7'd0,  6'd19, 6'b001000},
    '{9'd261, 7'd99, 6'd26, 6'b101001}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int flagsNow();
    return int'({hBlank, hSync, vBlank, vSync, displayOn, frameEnd});
  endfunction

  // Run one frame from the cycle after a frameEnd; optionally switch mode50.
  task automatic runFrame(input int switchAt, input logic newMode,
                          output int len, output int endLine, output int endRow);
    len = 0;
    do begin
      @(negedge clk);
      len++;
      if (len == switchAt) mode50 = newMode;
    end while (!frameEnd && len < 40000);
    endLine = int'(lineNum);
    endRow  = int'(charRow);
    @(negedge clk);
    check(lineNum == 0 && charRow == 0 && !frameEnd, "R10 wrap to line 0",
          int'(lineNum), 0);
  endtask

  initial begin : watchdog
    repeat (180000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    int len, eLine, eRow;
    repeat (3) @(negedge clk);
    // R11: reset state
    check(lineNum == 0 && charRow == 0, "R11 counters in reset", int'(lineNum), 0);
    check(flagsNow() == 6'b000010, "R11 flags in reset", flagsNow(), 6'b000010);
    rstN = 1'b1;
    pos = 0;

    // Table walk over one 60 Hz frame
    for (int i = 0; i < NVEC; i++) begin
      int target;
      target = int'(VECS[i].line) * 100 + int'(VECS[i].ch);
      while (pos < target) begin
        @(negedge clk);
        pos++;
      end
      check(lineNum == VECS[i].line, "R3 line number", int'(lineNum), int'(VECS[i].line));
      check(charRow == VECS[i].row, "R7 character row", int'(charRow), int'(VECS[i].row));
      check(flagsNow() == int'(VECS[i].flags), "R1/R2/R7/R8/R9/R10 flags",
            flagsNow(), int'(VECS[i].flags));
    end

    // First frame after reset was 60 Hz (R6): frameEnd seen at line 261
    check(pos == 26199 && frameEnd, "R4 first frame end", pos, 26199);
    @(negedge clk);
    check(lineNum == 0 && charRow == 0 && !frameEnd, "R10 wrap after first frame",
          int'(lineNum), 0);

    // Frame 2: mode switched to 50 Hz mid-frame, still 262 lines (R6)
    runFrame(4999, 1'b1, len, eLine, eRow);
    check(len == 26199, "R6 mid-frame switch keeps 60 Hz length", len + 1, 26200);
    check(eLine == 261, "R4 last line in 60 Hz", eLine, 261);

    // Frame 3: 50 Hz, switch back to 60 Hz mid-frame (R5, R6)
    runFrame(3000, 1'b0, len, eLine, eRow);
    check(len == 31399, "R5 50 Hz frame length", len + 1, 31400);
    check(eLine == 313, "R5 last line in 50 Hz", eLine, 313);
    check(eRow == 31, "R7 last character row in 50 Hz", eRow, 31);

    // Frame 4: back to 60 Hz (R4, R6)
    runFrame(0, 1'b0, len, eLine, eRow);
    check(len == 26199, "R4 60 Hz frame length after return", len + 1, 26200);
    check(eLine == 261, "R6 switch back took effect", eLine, 261);

    // Mid-frame reset returns to the start state (R11)
    repeat (12345) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(lineNum == 0 && charRow == 0, "R11 counters after mid-frame reset",
          int'(lineNum), 0);
    check(flagsNow() == 6'b000010, "R11 flags after mid-frame reset",
          flagsNow(), 6'b000010);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule